// File: doc/BRIEF.md
# Processor Bus Ownership Controller

This block decides who owns the external processor bus at each clock. On the core side it takes one bus cycle request at a time: an address of quadword granularity, byte enables, a cycle definition and a burst flag. It issues that request on the bus with a one-clock address strobe, counts ready returns until the cycle ends, and then pulses a completion flag back to the core. On the system side it answers two kinds of ownership requests from other masters.

A hold request is graceful. Any cycle already on the bus is allowed to finish. The outputs are then released and an acknowledge is raised, and it stays up until the request goes away. While the core marks a locked read-modify-write sequence as active, no hold is granted. A backoff request is abrupt. It releases the bus in the next clock, even in the middle of a cycle. When it is removed, the aborted cycle is issued again from its first beat, using the fields that were latched for it.

All strobes and flags are active high. Pad inversion and tristate buffers sit outside this block and are controlled by the float enable. Address parity is grouped: each group of address bits has its own even-parity bit.

Top module: `bus_own_ctrl`

## Requirements
- R1: While reset is asserted and in the first clock after it, strobe, hold acknowledge, float enable and completion are all low.
- R2: A new cycle starts only when no cycle is on the bus and no ownership is granted. Its strobe is high for exactly one clock, and in that clock the address, byte enable and definition outputs equal the core's request.
- R3: A cycle ends on the first ready return if it is a single cycle, and on the BURST_LEN-th ready return if it is a burst. Ready is sampled from the clock after the strobe onward, so the shortest cycle takes two clocks. Completion is pulsed in the clock of the final ready.
- R4: A hold request is granted only when no cycle is on the bus and no aborted cycle awaits restart. The acknowledge and float enable rise in the clock after the grant decision, and any outstanding cycle finishes before the grant.
- R5: The acknowledge and float enable stay high while the hold request stays high. They fall in the clock after the request falls, and no strobe appears in that same clock.
- R6: No hold is granted while the core's lock input is high. A pending core cycle is issued instead.
- R7: A backoff request sampled at a clock edge raises float enable in the following clock, from any state. It aborts any cycle on the bus without a completion pulse, and it drops any hold acknowledge.
- R8: When backoff and hold are both requested, backoff wins.
- R9: After backoff is released, an aborted cycle is re-issued from its first beat before any hold grant or new core cycle. The re-issued cycle carries the latched address, byte enables, definition and burst flag of the aborted cycle.
- R10: The bus request output is high in every clock in which the core request is high or an aborted cycle awaits restart.
- R11: Each parity output bit is set so that its address group, together with that bit, holds an even number of ones. It is valid in the same clock as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req_i | input | 1 | Core has a cycle to run; held until completion |
| core_addr_i | input | ADDR_W | Quadword address of the request |
| core_be_i | input | BE_W | Byte enables of the request |
| core_def_i | input | DEF_W | Cycle definition (memory/IO, data/code, write/read) |
| core_burst_i | input | 1 | Request is a BURST_LEN-beat burst |
| core_lock_i | input | 1 | Locked sequence active; blocks hold grants |
| core_done_o | output | 1 | Pulse on the final ready of a cycle |
| hold_req_i | input | 1 | Graceful ownership request from another master |
| hold_ack_o | output | 1 | Bus released in answer to a hold request |
| backoff_i | input | 1 | Immediate release request |
| rdy_i | input | 1 | Ready return for one beat |
| ads_o | output | 1 | Address strobe, one clock per issued cycle |
| bus_req_o | output | 1 | A cycle is pending inside the unit |
| float_en_o | output | 1 | Release address, data and control pads |
| addr_o | output | ADDR_W | Bus address |
| be_o | output | BE_W | Bus byte enables |
| def_o | output | DEF_W | Bus cycle definition |
| par_o | output | PAR_GROUPS | Even parity per address group |

## Verification
The bench builds the block with a 12-bit address, 4-beat bursts and two parity groups. The two groups select the per-group parity branch of the generate logic, and the short bursts let backoff land on every beat position within a few hundred clocks. The random mix of hold, lock and backoff requests, together with random ready gaps, reaches the corner cases: backoff and hold in the same clock, backoff while a hold is granted, hold raised in mid-burst, and lock going high exactly while a hold waits.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_DATA = 3'd2,
      ST_HELD = 3'd3,
      ST_BACK = 3'd4
   } own_st_e;
endpackage

// File: rtl/bus_addr_parity.sv
module bus_addr_parity #(
   parameter int ADDR_W = 29,
   parameter int GROUPS = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [GROUPS-1:0] par_o
);
   localparam int GRP_W = ADDR_W / GROUPS;

   if (GROUPS < 1 || (ADDR_W % GROUPS) != 0) begin : g_bad_groups
      $error("bus_addr_parity: ADDR_W must split evenly into GROUPS");
   end

   if (GROUPS == 1) begin : g_single
      assign par_o = ^addr_i;
   end else begin : g_multi
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         assign par_o[g] = ^addr_i[g*GRP_W +: GRP_W];
      end
   end
endmodule

// File: rtl/bus_cycle_latch.sv
module bus_cycle_latch #(
   parameter int ADDR_W = 29,
   parameter int BE_W   = 8,
   parameter int DEF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_new_i,
   input  logic              abort_i,
   input  logic              issue_restart_i,
   input  logic [ADDR_W-1:0] core_addr_i,
   input  logic [BE_W-1:0]   core_be_i,
   input  logic [DEF_W-1:0]  core_def_i,
   input  logic              core_burst_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BE_W-1:0]   be_q,
   output logic [DEF_W-1:0]  def_q,
   output logic              burst_q,
   output logic              restart_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         be_q    <= '0;
         def_q   <= '0;
         burst_q <= 1'b0;
      end else if (load_new_i) begin
         addr_q  <= core_addr_i;
         be_q    <= core_be_i;
         def_q   <= core_def_i;
         burst_q <= core_burst_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               restart_q <= 1'b0;
      else if (abort_i)         restart_q <= 1'b1;
      else if (issue_restart_i) restart_q <= 1'b0;
   end

   // R9
   restart_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |-> !load_new_i);

   // R9
   restart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_q |=> ($stable(addr_q) && $stable(be_q) && $stable(def_q) && $stable(burst_q)));
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
   import bus_own_pkg::*;
#(
   parameter int BURST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_req_i,
   input  logic restart_i,
   input  logic burst_i,
   input  logic hold_req_i,
   input  logic backoff_i,
   input  logic lock_i,
   input  logic rdy_i,
   output logic ads_o,
   output logic hold_ack_o,
   output logic float_en_o,
   output logic done_o,
   output logic load_new_o,
   output logic issue_restart_o,
   output logic abort_o
);
   localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

   if (BURST_LEN < 2) begin : g_bad_burst
      $error("bus_own_fsm: BURST_LEN must be at least 2");
   end

   own_st_e          st_q, st_d;
   logic [CNT_W-1:0] beat_q, beat_d;
   logic             last_beat, in_cycle, idle_free, grant;

   always_comb begin
      last_beat       = burst_i ? (beat_q == LAST_BEAT) : 1'b1;
      in_cycle        = (st_q == ST_ADDR) || (st_q == ST_DATA);
      idle_free       = (st_q == ST_IDLE) && !backoff_i;
      abort_o         = backoff_i && in_cycle;
      done_o          = (st_q == ST_DATA) && rdy_i && last_beat && !backoff_i;
      issue_restart_o = idle_free && restart_i;
      grant           = idle_free && !restart_i && hold_req_i && !lock_i;
      load_new_o      = idle_free && !restart_i && !(hold_req_i && !lock_i) && core_req_i;
   end

   always_comb begin
      st_d   = st_q;
      beat_d = beat_q;
      if (backoff_i) begin
         st_d = ST_BACK;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (issue_restart_o || load_new_o) st_d = ST_ADDR;
               else if (grant)                    st_d = ST_HELD;
            end
            ST_ADDR: begin
               st_d   = ST_DATA;
               beat_d = '0;
            end
            ST_DATA: begin
               if (rdy_i) begin
                  if (last_beat) st_d = ST_IDLE;
                  else           beat_d = beat_q + 1'b1;
               end
            end
            ST_HELD: if (!hold_req_i) st_d = ST_IDLE;
            ST_BACK: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
      end else begin
         st_q   <= st_d;
         beat_q <= beat_d;
      end
   end

   assign ads_o      = (st_q == ST_ADDR);
   assign hold_ack_o = (st_q == ST_HELD);
   assign float_en_o = (st_q == ST_HELD) || (st_q == ST_BACK);

   // R7
   boff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backoff_i |=> (float_en_o && !hold_ack_o && !ads_o));

   // R7
   boff_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backoff_i |-> !done_o);

   // R6
   lock_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack_o) |-> !$past(lock_i));

   // R4
   hold_req_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack_o) |-> $past(hold_req_i));

   // R5
   hold_exit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack_o) |-> !ads_o);

   // R5
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack_o && hold_req_i && !backoff_i) |=> hold_ack_o);

   // R2
   ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ads_o |=> !ads_o);
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl #(
   parameter int ADDR_W     = 29,
   parameter int BE_W       = 8,
   parameter int DEF_W      = 3,
   parameter int BURST_LEN  = 4,
   parameter int PAR_GROUPS = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  core_req_i,
   input  logic [ADDR_W-1:0]     core_addr_i,
   input  logic [BE_W-1:0]       core_be_i,
   input  logic [DEF_W-1:0]      core_def_i,
   input  logic                  core_burst_i,
   input  logic                  core_lock_i,
   output logic                  core_done_o,
   input  logic                  hold_req_i,
   output logic                  hold_ack_o,
   input  logic                  backoff_i,
   input  logic                  rdy_i,
   output logic                  ads_o,
   output logic                  bus_req_o,
   output logic                  float_en_o,
   output logic [ADDR_W-1:0]     addr_o,
   output logic [BE_W-1:0]       be_o,
   output logic [DEF_W-1:0]      def_o,
   output logic [PAR_GROUPS-1:0] par_o
);
   if (ADDR_W < 1 || BE_W < 1 || DEF_W < 1) begin : g_bad_width
      $error("bus_own_ctrl: widths must be positive");
   end

   logic load_new, abort, issue_restart, restart_q, burst_q;

   bus_own_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .core_req_i      (core_req_i),
      .restart_i       (restart_q),
      .burst_i         (burst_q),
      .hold_req_i      (hold_req_i),
      .backoff_i       (backoff_i),
      .lock_i          (core_lock_i),
      .rdy_i           (rdy_i),
      .ads_o           (ads_o),
      .hold_ack_o      (hold_ack_o),
      .float_en_o      (float_en_o),
      .done_o          (core_done_o),
      .load_new_o      (load_new),
      .issue_restart_o (issue_restart),
      .abort_o         (abort)
   );

   bus_cycle_latch #(.ADDR_W(ADDR_W), .BE_W(BE_W), .DEF_W(DEF_W)) u_latch (
      .clk             (clk),
      .rst_n           (rst_n),
      .load_new_i      (load_new),
      .abort_i         (abort),
      .issue_restart_i (issue_restart),
      .core_addr_i     (core_addr_i),
      .core_be_i       (core_be_i),
      .core_def_i      (core_def_i),
      .core_burst_i    (core_burst_i),
      .addr_q          (addr_o),
      .be_q            (be_o),
      .def_q           (def_o),
      .burst_q         (burst_q),
      .restart_q       (restart_q)
   );

   bus_addr_parity #(.ADDR_W(ADDR_W), .GROUPS(PAR_GROUPS)) u_par (
      .addr_i (addr_o),
      .par_o  (par_o)
   );

   assign bus_req_o = core_req_i || restart_q;

   // R10
   req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ads_o |-> bus_req_o);

   // R2
   ads_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ads_o |-> !float_en_o);
endmodule

// File: tb/tb_bus_own_ctrl.sv
module tb_bus_own_ctrl;
   localparam int  AW = 12, BEW = 8, DW = 3, BL = 4, PG = 2;
   localparam int  GW = AW / PG;
   localparam time CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic core_req = 0, core_burst = 0, core_lock = 0, hold_req = 0, backoff = 0, rdy = 0;
   logic [AW-1:0]  core_addr = '0;
   logic [BEW-1:0] core_be = '0;
   logic [DW-1:0]  core_def = '0;
   logic core_done, hold_ack, ads, bus_req, float_en;
   logic [AW-1:0]  addr;
   logic [BEW-1:0] be;
   logic [DW-1:0]  def;
   logic [PG-1:0]  par;

   int errors = 0, checks = 0;
   bit rdy_always = 1;

   // reference model state
   bit m_strobe, m_xfer, m_granted, m_backed, m_restart;
   int m_left;
   logic [AW-1:0]  s_addr;
   logic [BEW-1:0] s_be;
   logic [DW-1:0]  s_def;
   bit             s_burst;

   always #(CLK_P/2) clk = ~clk;

   bus_own_ctrl #(.ADDR_W(AW), .BE_W(BEW), .DEF_W(DW), .BURST_LEN(BL), .PAR_GROUPS(PG)) dut (
      .clk(clk), .rst_n(rst_n), .core_req_i(core_req), .core_addr_i(core_addr),
      .core_be_i(core_be), .core_def_i(core_def), .core_burst_i(core_burst),
      .core_lock_i(core_lock), .core_done_o(core_done), .hold_req_i(hold_req),
      .hold_ack_o(hold_ack), .backoff_i(backoff), .rdy_i(rdy), .ads_o(ads),
      .bus_req_o(bus_req), .float_en_o(float_en), .addr_o(addr), .be_o(be),
      .def_o(def), .par_o(par));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // one clock: inputs already driven at the falling edge
   task automatic step();
      bit e_done;
      logic [PG-1:0] e_par;
      #1;
      e_done = m_xfer && rdy && (m_left == 1) && !backoff;
      chk(ads == m_strobe, "R2", "strobe", 64'(ads), 64'(m_strobe));
      chk(core_done == e_done, "R3", "done", 64'(core_done), 64'(e_done));
      chk(hold_ack == m_granted, "R4 R5 R6 R8", "hold_ack", 64'(hold_ack), 64'(m_granted));
      chk(float_en == (m_granted || m_backed), "R7 R8", "float_en", 64'(float_en),
          64'(m_granted || m_backed));
      chk(bus_req == (core_req || m_restart), "R10", "bus_req", 64'(bus_req),
          64'(core_req || m_restart));
      if (m_strobe) begin
         chk(addr == s_addr, "R2 R9", "addr", 64'(addr), 64'(s_addr));
         chk(be == s_be, "R2 R9", "be", 64'(be), 64'(s_be));
         chk(def == s_def, "R2 R9", "def", 64'(def), 64'(s_def));
         for (int g = 0; g < PG; g++) e_par[g] = ^s_addr[g*GW +: GW];
         chk(par == e_par, "R11", "parity", 64'(par), 64'(e_par));
      end
      @(posedge clk);
      // advance the model with the inputs of this clock
      if (backoff) begin
         if (m_strobe || m_xfer) m_restart = 1;
         m_strobe = 0; m_xfer = 0; m_granted = 0; m_backed = 1;
      end else if (m_backed) begin
         m_backed = 0;
      end else if (m_granted) begin
         if (!hold_req) m_granted = 0;
      end else if (m_strobe) begin
         m_strobe = 0; m_xfer = 1; m_left = s_burst ? BL : 1;
      end else if (m_xfer) begin
         if (rdy) begin
            m_left--;
            if (m_left == 0) m_xfer = 0;
         end
      end else if (m_restart) begin
         m_restart = 0; m_strobe = 1;
      end else if (hold_req && !core_lock) begin
         m_granted = 1;
      end else if (core_req) begin
         s_addr = core_addr; s_be = core_be; s_def = core_def; s_burst = core_burst;
         m_strobe = 1;
      end
      @(negedge clk);
      if (e_done) core_req = 0;
   endtask

   task automatic cyc(input bit h, input bit b, input bit l);
      hold_req = h; backoff = b; core_lock = l;
      rdy = rdy_always ? 1'b1 : (($urandom % 3) != 0);
      if (!core_req && (($urandom % 4) != 0)) begin
         core_req   = 1;
         core_addr  = AW'($urandom);
         core_be    = BEW'($urandom);
         core_def   = DW'($urandom);
         core_burst = 1'($urandom % 2);
      end
      step();
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      chk(!ads && !hold_ack && !float_en && !core_done, "R1", "reset outputs",
          64'({ads, hold_ack, float_en, core_done}), 64'(0));
      @(negedge clk);
      rst_n = 1;
      #1;
      chk(!ads && !hold_ack && !float_en, "R1", "after reset",
          64'({ads, hold_ack, float_en}), 64'(0));
      // R2 R3: plain cycles, immediate ready
      for (int i = 0; i < 20; i++) cyc(0, 0, 0);
      // R3: ready with gaps
      rdy_always = 0;
      for (int i = 0; i < 40; i++) cyc(0, 0, 0);
      // R4 R5: graceful hold raised while traffic runs
      for (int i = 0; i < 15; i++) cyc(1, 0, 0);
      for (int i = 0; i < 10; i++) cyc(0, 0, 0);
      // R6: lock blocks the grant, then lock drops
      for (int i = 0; i < 10; i++) cyc(1, 0, 1);
      for (int i = 0; i < 8; i++)  cyc(1, 0, 0);
      for (int i = 0; i < 6; i++)  cyc(0, 0, 0);
      // R7 R9: backoff at varying beat offsets
      for (int k = 0; k < 12; k++) begin
         for (int i = 0; i < k % 5 + 1; i++) cyc(0, 0, 0);
         cyc(0, 1, 0);
         if (k % 2 == 1) cyc(0, 1, 0);
         for (int i = 0; i < 4; i++) cyc(0, 0, 0);
      end
      // R8: backoff and hold together
      for (int i = 0; i < 3; i++) cyc(1, 1, 0);
      for (int i = 0; i < 5; i++) cyc(1, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0);
      // R7 R8: backoff while a hold is granted
      for (int i = 0; i < 10; i++) cyc(1, 0, 0);
      for (int i = 0; i < 2; i++)  cyc(1, 1, 0);
      for (int i = 0; i < 4; i++)  cyc(1, 0, 0);
      for (int i = 0; i < 4; i++)  cyc(0, 0, 0);
      // random mix covering R2 to R11
      for (int i = 0; i < 2000; i++)
         cyc(($urandom % 5) == 0, ($urandom % 11) == 0, ($urandom % 4) == 0);
      summary();
   end
endmodule